// File: doc/BRIEF.md
# MSI Doorbell to Interrupt-Line Frame

This block is a small memory-mapped frame that turns message-signalled interrupt writes into edge events on a bank of shared peripheral interrupt (SPI) lines. A device posts a 32-bit write to the frame. The frame works out which SPI that write names. If that SPI belongs to the frame's assigned window, the frame raises the matching output line for exactly one clock. A downstream interrupt controller treats that pulse as a rising edge.

Parameters fix the window: the first SPI and the number of SPIs. They also fix an identification value and one of four encodings. The absolute encoding decodes data as the SPI number itself. The base-relative encoding decodes data as an offset from the first SPI. The fixed-offset encoding decodes data as the SPI number minus 32. The address-only encoding takes the SPI number from the write address and ignores the data.

Two read-only registers describe the frame to software. A valid configuration has a first SPI of at least 32, a count of at least 1, and a first SPI plus count of no more than 1019. The integrator must respect these limits; the frame does not check them.

Top module: `msi_spi_frame`

## Requirements
- R1: While reset is held and in the first cycle after it, `spi_pulse` is all zeros.
- R2: A read at byte offset 0x008 returns the window description: `SPI_FIRST` in bits [25:16], `SPI_COUNT` in bits [9:0], and zeros in every other bit.
- R3: A read at byte offset 0xFCC returns `IDENT_VALUE` in the three data-carrying encodings and zero in the address-only encoding (`ENCODING` = 3).
- R4: A read at any other offset returns zero. Writes never change what a read returns. In encodings 0 to 2, a write to any offset other than 0x040 produces no pulse. Address bits [1:0] are ignored by the register decode.
- R5: In encoding 0, a write to offset 0x040 with data D selects SPI D.
- R6: In encoding 1, a write to offset 0x040 with data D selects SPI `SPI_FIRST` + D, computed without wrap-around.
- R7: In encoding 2, a write to offset 0x040 with data D selects SPI D + 32, computed without wrap-around.
- R8: In encoding 3, a write at any byte offset A in the 8 KiB frame selects SPI 32 + (A >> 3), and the write data has no effect.
- R9: A write whose selected SPI lies outside [`SPI_FIRST`, `SPI_FIRST` + `SPI_COUNT` − 1] produces no pulse.
- R10: An accepted write sets bit (SPI − `SPI_FIRST`) of `spi_pulse` in the cycle after the write. That bit returns to zero one cycle later unless another write is accepted.
- R11: At most one bit of `spi_pulse` is ever high. Writes accepted on consecutive cycles each produce their own pulse on consecutive cycles, and none is lost.

Top module port list:

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bus_addr | input | ADDR_W | Byte offset inside the frame |
| bus_wdata | input | 32 | Write data |
| bus_we | input | 1 | Write strobe, one write per cycle |
| bus_rdata | output | 32 | Read data for `bus_addr` (combinational) |
| spi_pulse | output | SPI_COUNT | One-cycle edge pulse per SPI; bit i is SPI `SPI_FIRST` + i |

## Verification
The frame holds one piece of state: the registered pulse vector. A wrong decode or range test therefore shows on the very next cycle, as a missing pulse, a pulse on the wrong line, or a stray pulse. A stuck bit, or a pulse that does not clear, shows one cycle after that. The register reads are combinational, so a wrong field layout or a wrong identification gating is visible in the same cycle the address is applied. Window edges, values just outside the window, and all-ones data are the places where an off-by-one or a wrap-around in the adder would show up at the ports.

// File: rtl/msi_spi_frame.sv
module msi_spi_frame #(
  parameter int          SPI_FIRST   = 64,
  parameter int          SPI_COUNT   = 32,
  parameter logic [31:0] IDENT_VALUE = 32'h0000_0000,
  parameter int          ENCODING    = 0,
  parameter int          ADDR_W      = 13
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic [ADDR_W-1:0]    bus_addr,
  input  logic [31:0]          bus_wdata,
  input  logic                 bus_we,
  output logic [31:0]          bus_rdata,
  output logic [SPI_COUNT-1:0] spi_pulse
);

  localparam int IDX_W = (SPI_COUNT > 1) ? $clog2(SPI_COUNT) : 1;
  localparam logic [32:0] LO = 33'(SPI_FIRST);
  localparam logic [32:0] HI = 33'(SPI_FIRST + SPI_COUNT);
  localparam logic [31:0] TYPE_WORD = {6'b0, 10'(SPI_FIRST), 6'b0, 10'(SPI_COUNT)};
  localparam bit ADDR_ONLY = (ENCODING == 3);

  logic [ADDR_W-3:0] word;
  logic              at_type, at_ident, at_door;
  logic [32:0]       spi_num, rel;
  logic              accept;

  assign word     = bus_addr[ADDR_W-1:2];
  assign at_type  = (32'(word) == 32'h0000_0002);
  assign at_ident = (32'(word) == 32'h0000_03F3);
  assign at_door  = ADDR_ONLY ? 1'b1 : (32'(word) == 32'h0000_0010);

  always_comb begin
    case (ENCODING)
      0:       spi_num = {1'b0, bus_wdata};
      1:       spi_num = {1'b0, bus_wdata} + LO;
      2:       spi_num = {1'b0, bus_wdata} + 33'd32;
      default: spi_num = 33'd32 + 33'(bus_addr >> 3);
    endcase
  end

  assign rel    = spi_num - LO;
  assign accept = bus_we && at_door && (spi_num >= LO) && (spi_num < HI);

  assign bus_rdata = at_type                 ? TYPE_WORD   :
                     (at_ident && !ADDR_ONLY) ? IDENT_VALUE : 32'h0;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      spi_pulse <= '0;
    end else begin
      spi_pulse <= '0;
      if (accept) spi_pulse[rel[IDX_W-1:0]] <= 1'b1;
    end
  end

  assert_one_line_R11: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(spi_pulse));

  assert_pulse_needs_write_R10: assert property (@(posedge clk) disable iff (!rst_n)
    !bus_we |=> (spi_pulse == '0));

  assert_ro_write_quiet_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (!ADDR_ONLY && bus_we && (32'(word) != 32'h0000_0010)) |=> (spi_pulse == '0));

  assert_read_stable_R4: assert property (@(posedge clk) disable iff (!rst_n)
    $stable(bus_addr) |-> $stable(bus_rdata));

endmodule

// File: tb/sim_msi_spi_frame.sv
`timescale 1ns/1ps
module sim_msi_spi_frame;
  logic clk = 0;
  always #4 clk = ~clk;

  logic        rst_n;
  logic [12:0] addr;
  logic [31:0] wdata;
  logic [3:0]  we;
  logic [31:0] rd0, rd1, rd2, rd3;
  logic [31:0] p0;
  logic [7:0]  p1, p2;
  logic [15:0] p3;
  int checks = 0, failures = 0;

  msi_spi_frame #(.SPI_FIRST(64), .SPI_COUNT(32), .IDENT_VALUE(32'h1234_0043), .ENCODING(0)) u0 (
    .clk(clk), .rst_n(rst_n), .bus_addr(addr), .bus_wdata(wdata), .bus_we(we[0]),
    .bus_rdata(rd0), .spi_pulse(p0));
  msi_spi_frame #(.SPI_FIRST(96), .SPI_COUNT(8), .IDENT_VALUE(32'h0600_0170), .ENCODING(1)) u1 (
    .clk(clk), .rst_n(rst_n), .bus_addr(addr), .bus_wdata(wdata), .bus_we(we[1]),
    .bus_rdata(rd1), .spi_pulse(p1));
  msi_spi_frame #(.SPI_FIRST(40), .SPI_COUNT(8), .IDENT_VALUE(32'h0000_013F), .ENCODING(2)) u2 (
    .clk(clk), .rst_n(rst_n), .bus_addr(addr), .bus_wdata(wdata), .bus_we(we[2]),
    .bus_rdata(rd2), .spi_pulse(p2));
  msi_spi_frame #(.SPI_FIRST(40), .SPI_COUNT(16), .IDENT_VALUE(32'hABCD_0001), .ENCODING(3)) u3 (
    .clk(clk), .rst_n(rst_n), .bus_addr(addr), .bus_wdata(wdata), .bus_we(we[3]),
    .bus_rdata(rd3), .spi_pulse(p3));

  typedef struct packed {
    logic [1:0]  sel;
    logic [12:0] a;
    logic [31:0] d;
    logic        hit;
    logic [5:0]  idx;
  } vec_t;

  localparam int NV = 24;
  localparam vec_t VEC [0:NV-1] = '{
    '{2'd0, 13'h040, 32'd64,         1'b1, 6'd0 },  // R5 first line
    '{2'd0, 13'h040, 32'd95,         1'b1, 6'd31},  // R5 last line
    '{2'd0, 13'h040, 32'd80,         1'b1, 6'd16},  // R5
    '{2'd0, 13'h042, 32'd70,         1'b1, 6'd6 },  // R4 low address bits ignored
    '{2'd0, 13'h040, 32'd63,         1'b0, 6'd0 },  // R9 below window
    '{2'd0, 13'h040, 32'd96,         1'b0, 6'd0 },  // R9 above window
    '{2'd0, 13'h040, 32'hFFFF_FFFF,  1'b0, 6'd0 },  // R9
    '{2'd0, 13'h044, 32'd70,         1'b0, 6'd0 },  // R4 not the doorbell
    '{2'd0, 13'h008, 32'd70,         1'b0, 6'd0 },  // R4 write to type register
    '{2'd1, 13'h040, 32'd0,          1'b1, 6'd0 },  // R6
    '{2'd1, 13'h040, 32'd7,          1'b1, 6'd7 },  // R6
    '{2'd1, 13'h040, 32'd8,          1'b0, 6'd0 },  // R9
    '{2'd1, 13'h040, 32'hFFFF_FFFF,  1'b0, 6'd0 },  // R6 no wrap
    '{2'd2, 13'h040, 32'd8,          1'b1, 6'd0 },  // R7
    '{2'd2, 13'h040, 32'd15,         1'b1, 6'd7 },  // R7
    '{2'd2, 13'h040, 32'd7,          1'b0, 6'd0 },  // R9
    '{2'd2, 13'h040, 32'd16,         1'b0, 6'd0 },  // R9
    '{2'd2, 13'h040, 32'hFFFF_FFF0,  1'b0, 6'd0 },  // R7 no wrap
    '{2'd3, 13'd64,  32'd0,          1'b1, 6'd0 },  // R8
    '{2'd3, 13'd71,  32'hDEAD_BEEF,  1'b1, 6'd0 },  // R8 data ignored
    '{2'd3, 13'd184, 32'd5,          1'b1, 6'd15},  // R8
    '{2'd3, 13'd192, 32'd45,         1'b0, 6'd0 },  // R9
    '{2'd3, 13'd63,  32'd40,         1'b0, 6'd0 },  // R9
    '{2'd3, 13'h1FF8,32'd40,         1'b0, 6'd0 }   // R8 top of frame
  };

  function automatic logic [31:0] pulse_of(input logic [1:0] s);
    case (s)
      2'd0:    return p0;
      2'd1:    return {24'b0, p1};
      2'd2:    return {24'b0, p2};
      default: return {16'b0, p3};
    endcase
  endfunction

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic do_write(input logic [1:0] s, input logic [12:0] a, input logic [31:0] d);
    @(negedge clk);
    addr = a; wdata = d; we = 4'b0001 << s;
    @(negedge clk);
    we = 4'b0;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    failures++;
    $display("FAIL watchdog expired");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    rst_n = 0; addr = '0; wdata = '0; we = '0;
    repeat (3) @(negedge clk);
    check("R1 reset u0", p0, 32'h0);
    check("R1 reset u3", {16'b0, p3}, 32'h0);
    rst_n = 1;
    @(negedge clk);
    check("R1 after reset", p0 | {24'b0, p1} | {24'b0, p2} | {16'b0, p3}, 32'h0);

    for (int i = 0; i < NV; i++) begin
      do_write(VEC[i].sel, VEC[i].a, VEC[i].d);
      check(VEC[i].hit ? "R10 accepted pulse" : "R9 dropped write", pulse_of(VEC[i].sel),
            VEC[i].hit ? (32'h1 << VEC[i].idx) : 32'h0);
      @(negedge clk);
      check("R10 single cycle", pulse_of(VEC[i].sel), 32'h0);
    end

    addr = 13'h008; #1;
    check("R2 type u0", rd0, 32'h0040_0020);
    check("R2 type u3", rd3, 32'h0028_0010);
    addr = 13'h00B; #1;
    check("R2 low bits ignored", rd1, 32'h0060_0008);
    addr = 13'hFCC; #1;
    check("R3 ident u0", rd0, 32'h1234_0043);
    check("R3 ident u2", rd2, 32'h0000_013F);
    check("R3 ident addr-only", rd3, 32'h0);
    addr = 13'h040; #1;
    check("R4 doorbell reads zero", rd0, 32'h0);
    addr = 13'h100; #1;
    check("R4 unmapped", rd0, 32'h0);

    do_write(2'd0, 13'hFCC, 32'h5555_5555);
    check("R4 write to ident no pulse", p0, 32'h0);
    addr = 13'hFCC; #1;
    check("R4 ident unchanged", rd0, 32'h1234_0043);

    @(negedge clk);
    addr = 13'h040; wdata = 32'd70; we = 4'b0001;
    @(negedge clk);
    wdata = 32'd72;
    check("R11 first of pair", p0, 32'h1 << 6);
    @(negedge clk);
    we = 4'b0;
    check("R11 second of pair", p0, 32'h1 << 8);
    @(negedge clk);
    check("R11 pair done", p0, 32'h0);

    @(negedge clk);
    addr = 13'h040; wdata = 32'd90; we = 4'b0001;
    @(negedge clk);
    check("R11 repeat line first", p0, 32'h1 << 26);
    @(negedge clk);
    we = 4'b0;
    check("R11 repeat line second", p0, 32'h1 << 26);
    @(negedge clk);
    check("R10 repeat line clears", p0, 32'h0);

    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule